// File: doc/BRIEF.md
# Disk adapter attention and interrupt front end

This block is the byte-wide host-facing register front end of a fixed-disk adapter. The host writes a control byte (adapter reset, DMA enable, interrupt enable) and an attention byte, and it reads a status byte and an interrupt status byte. An attention byte names a target (the adapter itself or one of two drives) and a request (command, end of interrupt, adapter reset). The front end turns these into one-cycle strobes for a command sequencer behind it. It also keeps the status flags and the interrupt latch, and drives the interrupt line.

The sequencer reports progress through a valid/ready event stream. An event carries a 4-bit code and a 3-bit device number. `evt_ready` is low while an adapter reset sequence is running or while the reset bit is held. The sequencer must keep `evt_valid`, `evt_code` and `evt_dev` steady until the event is taken on a rising edge with `evt_ready` high. A timed adapter reset sequence of `RST_CYCLES` clock cycles runs after power-up, after the host releases the reset bit, and after an adapter reset attention. When it ends, the block posts a reset-complete interrupt.

Top module: `dsk_attn_front`

## Requirements
- R1: After `rst_n` is released, before any clock edge, the status byte reads 0x10 (busy only), the interrupt status byte reads 0xFF, and `irq_o` and `err_o` are low.
- R2: The power-up reset sequence completes on the `RST_CYCLES`-th rising edge after `rst_n` is released. Until then the status reads busy. From then on the status reads 0x4B (interrupt latched, status-out full, transfer request, interrupt bit) and the interrupt status reads 0xEA (device 7, code 0xA).
- R3: When a control write takes bit 7 (reset) from 1 to 0, a reset sequence starts. The status becomes exactly busy (latch cleared), `err_o` clears, and `seq_reset` pulses with `seq_dev` = 7. The sequence completes `RST_CYCLES` edges after the write edge, as in R2.
- R4: When a control write takes bit 7 from 0 to 1, any running sequence is cancelled. The status becomes exactly busy, `seq_reset` pulses, and no completion occurs while the bit stays set.
- R5: An attention byte has the target in bits 7:5 (7 = adapter, 0 = drive 0, 1 = drive 1) and the request in bits 4:0 (0x01 = command, 0x02 = end of interrupt, 0x04 = reset). A command request records the target, sets status bit 4 (busy) and pulses `seq_rewind` with `seq_dev` equal to the target. A later `cmd_words_done` pulse makes the status exactly busy and pulses `seq_start` with the recorded target.
- R6: A command request that arrives while a previous one is still collecting words sets `err_o` and changes nothing else.
- R7: An end-of-interrupt request to any valid target clears the interrupt latch (status bit 6) and status bit 0, drops `irq_o`, and pulses `seq_eoi` with the target.
- R8: Reading the interrupt status byte (`rd_en` with `rd_sel`=1) returns {device[7:5], 0, code[3:0]} and clears status bit 0. It leaves the latch and `irq_o` unchanged.
- R9: `irq_o` is high exactly when the interrupt latch is set and control bit 0 is set, so setting the enable later raises a latched interrupt.
- R10: A reset request is accepted only for target 7. For it, the status becomes busy, `err_o` clears, `seq_reset` pulses and a sequence starts. A reset request to a drive sets `err_o` and changes nothing else.
- R11: An attention byte with an unknown request code, a set bit 4, or a target other than 7, 0 or 1 sets `err_o` and is otherwise ignored. `err_o` stays set until the next reset sequence starts.
- R12: An accepted event with code 0xB makes status bits 5:0 equal 0x23 (command in progress, transfer request, interrupt). Any other code makes them 0x09 (status-out full, interrupt). Both set the latch and load the interrupt status with {dev, 0, code}. `evt_ready` is low during a reset sequence or hold.
- R13: Status bit 7 always mirrors control bit 1 (DMA enable); status bit 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = attention register |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe (side effect only for `rd_sel`=1) |
| rd_sel | input | 1 | 0 = status byte, 1 = interrupt status byte |
| rd_data | output | 8 | Selected read byte |
| cmd_words_done | input | 1 | Pulse from word buffer: command words all received |
| evt_valid | input | 1 | Sequencer event valid |
| evt_ready | output | 1 | Event can be taken |
| evt_code | input | 4 | Event code (0xB transfer ready, others completion) |
| evt_dev | input | 3 | Device the event belongs to |
| seq_rewind | output | 1 | Pulse: rewind command/status word pointers |
| seq_start | output | 1 | Pulse: run the collected command |
| seq_eoi | output | 1 | Pulse: end of interrupt acknowledged |
| seq_reset | output | 1 | Pulse: reset sequence started or reset held |
| seq_dev | output | 3 | Target of the current strobe |
| irq_o | output | 1 | Interrupt line |
| err_o | output | 1 | Sticky attention error flag |

## Verification
The bench builds the block with `RST_CYCLES` = 6 instead of its long default. With that value, the exact edge on which a reset sequence completes falls within a short run and is checked from both sides: power-up, release of the reset bit, and the adapter reset attention. A ten-cycle hold that is longer than the whole sequence shows that cancellation lasts. Every sequencer strobe is predicted into a queue and matched as it appears, so a missing, extra or misdirected strobe is caught.

// File: rtl/dsk_attn_pkg.sv
package dsk_attn_pkg;
  localparam int CTL_RST_BIT = 7;
  localparam int CTL_DMA_BIT = 1;
  localparam int CTL_IE_BIT  = 0;

  localparam logic [2:0] DEV_ADAPTER = 3'd7;
  localparam logic [2:0] DEV_DRIVE0  = 3'd0;
  localparam logic [2:0] DEV_DRIVE1  = 3'd1;

  localparam logic [4:0] REQ_CMD = 5'h01;
  localparam logic [4:0] REQ_EOI = 5'h02;
  localparam logic [4:0] REQ_RST = 5'h04;

  localparam logic [3:0] EVT_XFER_READY = 4'hB;
  localparam logic [3:0] CODE_RST_DONE  = 4'hA;

  // low six status bits: [5] cmd in progress, [4] busy, [3] out full,
  // [2] cmd-in full (unused), [1] transfer request, [0] interrupt
  localparam logic [5:0] ST_BUSY     = 6'h10;
  localparam logic [5:0] ST_XFER     = 6'h23;
  localparam logic [5:0] ST_DONE     = 6'h09;
  localparam logic [5:0] ST_RST_DONE = 6'h0B;

  localparam logic [7:0] IRQST_POWERUP = 8'hFF;
endpackage

// File: rtl/dsk_attn_decode.sv
module dsk_attn_decode
  import dsk_attn_pkg::*;
(
  input  logic       wr,
  input  logic [7:0] attn,
  output logic       is_cmd,
  output logic       is_eoi,
  output logic       is_rst,
  output logic       is_bad,
  output logic [2:0] dev
);
  logic [4:0] req;
  logic       dev_ok;

  assign dev    = attn[7:5];
  assign req    = attn[4:0];
  assign dev_ok = (dev == DEV_ADAPTER) || (dev == DEV_DRIVE0) || (dev == DEV_DRIVE1);

  assign is_cmd = wr && dev_ok && (req == REQ_CMD);
  assign is_eoi = wr && dev_ok && (req == REQ_EOI);
  assign is_rst = wr && (dev == DEV_ADAPTER) && (req == REQ_RST);
  assign is_bad = wr && !(is_cmd || is_eoi || is_rst);
endmodule

// File: rtl/dsk_rst_timer.sv
module dsk_rst_timer #(
  parameter int unsigned RST_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic active,
  output logic done
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign active = act_q;
  assign done   = act_q && (cnt_q == ONE) && !start && !cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      cnt_q <= LOAD;
    end else if (cancel) begin
      act_q <= 1'b0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= LOAD;
    end else if (act_q) begin
      if (cnt_q == ONE) act_q <= 1'b0;
      else              cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/dsk_attn_front.sv
module dsk_attn_front
  import dsk_attn_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic       cmd_words_done,
  input  logic       evt_valid,
  output logic       evt_ready,
  input  logic [3:0] evt_code,
  input  logic [2:0] evt_dev,
  output logic       seq_rewind,
  output logic       seq_start,
  output logic       seq_eoi,
  output logic       seq_reset,
  output logic [2:0] seq_dev,
  output logic       irq_o,
  output logic       err_o
);
  logic       ctrl_rst_q, ctrl_dma_q, ctrl_ie_q;
  logic [5:0] stat_q;
  logic       irq_latch_q;
  logic [7:0] irqst_q;
  logic       collect_q;
  logic [2:0] cmd_dev_q;

  logic       wr_ctrl, wr_attn, rel, hold, rst_go;
  logic       d_cmd, d_eoi, d_rst, d_bad;
  logic [2:0] d_dev;
  logic       cmd_ok, cmd_dup, evt_fire;
  logic       tmr_active, tmr_done;

  assign wr_ctrl = wr_en && !wr_sel;
  assign wr_attn = wr_en && wr_sel;
  assign rel     = wr_ctrl && ctrl_rst_q && !wr_data[CTL_RST_BIT];
  assign hold    = wr_ctrl && !ctrl_rst_q && wr_data[CTL_RST_BIT];

  dsk_attn_decode u_dec (
    .wr     (wr_attn),
    .attn   (wr_data),
    .is_cmd (d_cmd),
    .is_eoi (d_eoi),
    .is_rst (d_rst),
    .is_bad (d_bad),
    .dev    (d_dev)
  );

  assign rst_go  = rel || d_rst;
  assign cmd_ok  = d_cmd && !collect_q;
  assign cmd_dup = d_cmd && collect_q;

  dsk_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rst_go),
    .cancel (hold),
    .active (tmr_active),
    .done   (tmr_done)
  );

  assign evt_ready = !tmr_active && !ctrl_rst_q;
  assign evt_fire  = evt_valid && evt_ready;

  assign rd_data = rd_sel ? irqst_q : {ctrl_dma_q, irq_latch_q, stat_q};
  assign irq_o   = irq_latch_q && ctrl_ie_q;

  // later statements win: read side effect, then sequencer, then host writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_rst_q  <= 1'b0;
      ctrl_dma_q  <= 1'b0;
      ctrl_ie_q   <= 1'b0;
      stat_q      <= ST_BUSY;
      irq_latch_q <= 1'b0;
      irqst_q     <= IRQST_POWERUP;
      collect_q   <= 1'b0;
      cmd_dev_q   <= DEV_ADAPTER;
      err_o       <= 1'b0;
      seq_rewind  <= 1'b0;
      seq_start   <= 1'b0;
      seq_eoi     <= 1'b0;
      seq_reset   <= 1'b0;
      seq_dev     <= DEV_ADAPTER;
    end else begin
      seq_rewind <= 1'b0;
      seq_start  <= 1'b0;
      seq_eoi    <= 1'b0;
      seq_reset  <= 1'b0;

      if (rd_en && rd_sel) stat_q[0] <= 1'b0;

      if (evt_fire) begin
        stat_q      <= (evt_code == EVT_XFER_READY) ? ST_XFER : ST_DONE;
        irq_latch_q <= 1'b1;
        irqst_q     <= {evt_dev, 1'b0, evt_code};
      end
      if (tmr_done) begin
        stat_q      <= ST_RST_DONE;
        irq_latch_q <= 1'b1;
        irqst_q     <= {DEV_ADAPTER, 1'b0, CODE_RST_DONE};
      end

      if (wr_ctrl) begin
        ctrl_rst_q <= wr_data[CTL_RST_BIT];
        ctrl_dma_q <= wr_data[CTL_DMA_BIT];
        ctrl_ie_q  <= wr_data[CTL_IE_BIT];
      end

      if (rst_go || hold) begin
        stat_q      <= ST_BUSY;
        irq_latch_q <= 1'b0;
        collect_q   <= 1'b0;
        seq_reset   <= 1'b1;
        seq_dev     <= DEV_ADAPTER;
      end
      if (rst_go) err_o <= 1'b0;
      if (cmd_dup || d_bad) err_o <= 1'b1;

      if (cmd_ok) begin
        collect_q  <= 1'b1;
        cmd_dev_q  <= d_dev;
        stat_q[4]  <= 1'b1;
        seq_rewind <= 1'b1;
        seq_dev    <= d_dev;
      end
      if (d_eoi) begin
        irq_latch_q <= 1'b0;
        stat_q[0]   <= 1'b0;
        seq_eoi     <= 1'b1;
        seq_dev     <= d_dev;
      end
      if (cmd_words_done && collect_q) begin
        collect_q <= 1'b0;
        stat_q    <= ST_BUSY;
        seq_start <= 1'b1;
        seq_dev   <= cmd_dev_q;
      end
    end
  end
endmodule

// File: rtl/dsk_attn_front_chk.sv
module dsk_attn_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       cmd_words_done,
  input logic       evt_fire,
  input logic [3:0] evt_code,
  input logic       ctrl_rst_q,
  input logic [5:0] stat_q,
  input logic       irq_latch_q,
  input logic [7:0] irqst_q,
  input logic       collect_q,
  input logic       tmr_active,
  input logic       tmr_done,
  input logic       seq_start,
  input logic       seq_reset,
  input logic       irq_o,
  input logic       err_o
);
  logic attn_dev_ok;
  assign attn_dev_ok = (wr_data[7:5] == 3'd7) || (wr_data[7:5] <= 3'd1);

  // R7
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && attn_dev_ok && wr_data[4:0] == 5'h02) |=> (!irq_latch_q && !irq_o));

  // R3
  release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && ctrl_rst_q && !wr_data[7]) |=> (stat_q == 6'h10 && tmr_active));

  // R4
  hold_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_q) |-> !tmr_active);

  // R2
  rst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |=> (irqst_q == 8'hEA && irq_latch_q));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o || seq_reset));

  // R5
  start_after_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (!collect_q && $past(collect_q)));

  // R12
  evt_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fire && evt_code == 4'hB && !wr_en && !cmd_words_done) |=> (stat_q[5] && stat_q[1] && irq_latch_q));
endmodule

bind dsk_attn_front dsk_attn_front_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_sel         (wr_sel),
  .wr_data        (wr_data),
  .cmd_words_done (cmd_words_done),
  .evt_fire       (evt_fire),
  .evt_code       (evt_code),
  .ctrl_rst_q     (ctrl_rst_q),
  .stat_q         (stat_q),
  .irq_latch_q    (irq_latch_q),
  .irqst_q        (irqst_q),
  .collect_q      (collect_q),
  .tmr_active     (tmr_active),
  .tmr_done       (tmr_done),
  .seq_start      (seq_start),
  .seq_reset      (seq_reset),
  .irq_o          (irq_o),
  .err_o          (err_o)
);

// File: tb/dsk_attn_front_bench.sv
`timescale 1ns/1ps
module dsk_attn_front_bench;
  localparam int unsigned NRST = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_sel, rd_en, rd_sel;
  logic [7:0] wr_data, rd_data;
  logic       words_done, evt_valid, evt_ready;
  logic [3:0] evt_code;
  logic [2:0] evt_dev, seq_dev;
  logic       seq_rewind, seq_start, seq_eoi, seq_reset, irq_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct packed { logic [1:0] kind; logic [2:0] dev; } strobe_t;
  localparam logic [1:0] K_REWIND = 2'd0, K_START = 2'd1, K_EOI = 2'd2, K_RESET = 2'd3;
  strobe_t expq[$];

  always #2.5 clk = ~clk;

  dsk_attn_front #(.RST_CYCLES(NRST)) u_dsk_attn_front (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .cmd_words_done(words_done),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code), .evt_dev(evt_dev),
    .seq_rewind(seq_rewind), .seq_start(seq_start), .seq_eoi(seq_eoi), .seq_reset(seq_reset),
    .seq_dev(seq_dev), .irq_o(irq_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // scoreboard monitor for sequencer strobes
  always @(negedge clk) begin
    if (rst_n && (seq_rewind || seq_start || seq_eoi || seq_reset)) begin
      strobe_t got;
      strobe_t exp;
      n_chk++;
      if ((32'(seq_rewind) + 32'(seq_start) + 32'(seq_eoi) + 32'(seq_reset)) != 1) begin
        n_fail++;
        $display("FAIL R5 strobes: several at once %b%b%b%b expected one",
                 seq_rewind, seq_start, seq_eoi, seq_reset);
      end else begin
        got.kind = seq_rewind ? K_REWIND : seq_start ? K_START : seq_eoi ? K_EOI : K_RESET;
        got.dev  = seq_dev;
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL R5 strobe: got kind %0d dev %0d expected none", got.kind, got.dev);
        end else begin
          exp = expq.pop_front();
          if (got !== exp) begin
            n_fail++;
            $display("FAIL R5 strobe: got kind %0d dev %0d expected kind %0d dev %0d",
                     got.kind, got.dev, exp.kind, exp.dev);
          end
        end
      end
    end
  end

  task automatic push(input logic [1:0] k, input logic [2:0] d);
    strobe_t s;
    s.kind = k;
    s.dev = d;
    expq.push_back(s);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic peek(input logic sel, output logic [7:0] v);
    rd_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  task automatic rd_irq(output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic send_evt(input logic [3:0] c, input logic [2:0] d);
    @(negedge clk);
    evt_valid = 1'b1; evt_code = c; evt_dev = d;
    while (!evt_ready) @(negedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
    #1;
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_en = 0; rd_sel = 0;
    words_done = 0; evt_valid = 0; evt_code = 0; evt_dev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    peek(1'b0, v); chk("R1 status", v, 8'h10);
    peek(1'b1, v); chk("R1 irq status", v, 8'hFF);
    chk("R1 irq_o", {7'd0, irq_o}, 8'h00);
    chk("R1 err_o", {7'd0, err_o}, 8'h00);

    negs(NRST - 1);
    peek(1'b0, v); chk("R2 busy before done", v, 8'h10);
    chk("R12 ready low in sequence", {7'd0, evt_ready}, 8'h00);
    negs(1);
    peek(1'b0, v); chk("R2 status done", v, 8'h4B);
    peek(1'b1, v); chk("R2 irq status", v, 8'hEA);
    chk("R9 irq_o gated off", {7'd0, irq_o}, 8'h00);
    chk("R12 ready high", {7'd0, evt_ready}, 8'h01);

    wr(1'b0, 8'h01);
    chk("R9 irq_o after enable", {7'd0, irq_o}, 8'h01);

    rd_irq(v); chk("R8 irq status read", v, 8'hEA);
    peek(1'b0, v); chk("R8 status bit0 cleared", v, 8'h4A);
    chk("R8 irq_o kept", {7'd0, irq_o}, 8'h01);

    push(K_EOI, 3'd7);
    wr(1'b1, 8'hE2);
    peek(1'b0, v); chk("R7 status after eoi", v, 8'h0A);
    chk("R7 irq_o low", {7'd0, irq_o}, 8'h00);

    push(K_REWIND, 3'd0);
    wr(1'b1, 8'h01);
    peek(1'b0, v); chk("R5 busy on command", v, 8'h1A);
    chk("R5 no error", {7'd0, err_o}, 8'h00);
    wr(1'b1, 8'h21);
    chk("R6 dup command error", {7'd0, err_o}, 8'h01);
    peek(1'b0, v); chk("R6 status unchanged", v, 8'h1A);
    push(K_START, 3'd0);
    @(negedge clk); words_done = 1'b1;
    @(negedge clk); words_done = 1'b0;
    #1;
    peek(1'b0, v); chk("R5 status on start", v, 8'h10);

    send_evt(4'hB, 3'd0);
    peek(1'b0, v); chk("R12 transfer ready status", v, 8'h63);
    peek(1'b1, v); chk("R12 transfer ready irq status", v, 8'h0B);
    chk("R12 irq_o", {7'd0, irq_o}, 8'h01);
    push(K_EOI, 3'd0);
    wr(1'b1, 8'h02);
    peek(1'b0, v); chk("R7 drive eoi status", v, 8'h22);
    send_evt(4'h1, 3'd1);
    peek(1'b0, v); chk("R12 completion status", v, 8'h49);
    peek(1'b1, v); chk("R12 completion irq status", v, 8'h21);

    push(K_RESET, 3'd7);
    wr(1'b0, 8'h81);
    peek(1'b0, v); chk("R4 hold status", v, 8'h10);
    chk("R4 irq_o low", {7'd0, irq_o}, 8'h00);
    chk("R12 ready low in hold", {7'd0, evt_ready}, 8'h00);
    negs(10);
    peek(1'b0, v); chk("R4 no completion while held", v, 8'h10);

    push(K_RESET, 3'd7);
    wr(1'b0, 8'h01);
    chk("R3 error cleared", {7'd0, err_o}, 8'h00);
    peek(1'b0, v); chk("R3 busy on release", v, 8'h10);
    negs(NRST - 1);
    peek(1'b0, v); chk("R3 busy before done", v, 8'h10);
    negs(1);
    peek(1'b0, v); chk("R3 done after release", v, 8'h4B);
    chk("R3 irq_o", {7'd0, irq_o}, 8'h01);

    wr(1'b0, 8'h03);
    peek(1'b0, v); chk("R13 dma mirror on", v, 8'hCB);
    wr(1'b0, 8'h01);
    peek(1'b0, v); chk("R13 dma mirror off", v, 8'h4B);
    wr(1'b0, 8'h03);

    wr(1'b1, 8'hE8);
    chk("R11 bad code error", {7'd0, err_o}, 8'h01);
    peek(1'b0, v); chk("R11 status unchanged", v, 8'hCB);

    push(K_RESET, 3'd7);
    wr(1'b1, 8'hE4);
    chk("R10 adapter reset clears error", {7'd0, err_o}, 8'h00);
    peek(1'b0, v); chk("R10 adapter reset busy", v, 8'h90);
    negs(NRST);
    peek(1'b0, v); chk("R10 adapter reset done", v, 8'hCB);
    wr(1'b1, 8'h04);
    chk("R10 drive reset rejected", {7'd0, err_o}, 8'h01);
    peek(1'b0, v); chk("R10 status unchanged", v, 8'hCB);
    wr(1'b1, 8'h41);
    peek(1'b0, v); chk("R11 bad device ignored", v, 8'hCB);
    wr(1'b1, 8'hF1);
    peek(1'b0, v); chk("R11 bit4 set ignored", v, 8'hCB);

    negs(3);
    chk("R5 all strobes seen", 8'(expq.size()), 8'h00);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule